// File: doc/BRIEF.md
# Calibrated Seconds Tick Generator

This block turns a slow crystal clock of roughly 33.33 kHz into a strobe that fires once per second. A 21-bit calibration word decides how long a second is. Its low sixteen bits give the integer number of crystal cycles, and a small fractional correction can add single extra cycles to some seconds so that long-term drift can be trimmed finer than one cycle per second.

The correction works over a window of sixteen seconds. A four-bit phase counter steps once per second. In every second whose phase is below the programmed fraction, the second is one cycle longer. Writing a new calibration word restarts the current second and the phase window, so software can line up the second boundary with the moment of the write. The running tick counter is brought out so that the position inside the current second can be read back.

Top module: `rtcSecTick`

## Requirements
- R1: After reset the calibration word is 0x198233: integer count 0x8233, fraction 9, correction enabled. The tick count reads 0, the seconds pulse is low, and the first pulse comes 33333 clock cycles after reset is released.
- R2: With bit 20 of the calibration word clear and integer count N in bits 15:0, the seconds pulse comes every N+1 clock cycles.
- R3: The seconds pulse is high for exactly one clock cycle when N is at least 1.
- R4: With bit 20 set and fraction F in bits 19:16, the phase counter starts at 0 and steps once per pulse, modulo 16. A second whose phase is below F lasts N+2 cycles; every other second lasts N+1. Sixteen consecutive seconds therefore total 16*(N+1)+F cycles.
- R5: While bit 20 is clear, bits 19:16 have no effect on the length of any second.
- R6: A calibration write clears the tick count in the cycle after the write and drops any pulse. The next pulse comes one full second, as set by the new word, after the write edge. This holds even when the write lands in the middle of a second.
- R7: A calibration write resets the phase counter to 0, so the first second after a write is lengthened whenever F > 0 and correction is enabled.
- R8: Bits of the write data above bit 20 are ignored.
- R9: Between pulses the tick count rises by one per clock cycle, starting at 0 after a pulse or a write. It reads 0 in the cycle the pulse is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Crystal clock |
| rstN | input | 1 | Asynchronous active-low reset |
| calWr | input | 1 | Calibration write strobe, one cycle per write |
| calData | input | 32 | Write data; only bits 20:0 are kept |
| secPulse | output | 1 | One-cycle seconds strobe |
| tickCount | output | 16 | Live position inside the current second |

## Verification
The main timing is tried with several calibration words, in each case measuring the first second after a write and the total of sixteen seconds. The words cover integer-only counts, an enabled fraction of zero, small and full fractions, fraction bits present with correction disabled, and data with high junk bits. The first-second length separates a phase reset from a missing one, and the sixteen-second total separates correct fraction accounting from an off-by-one in the phase compare. Directed runs follow: the default one-second period after reset, a tick-by-tick ramp of the counter, a rewrite in mid-second, and a rewrite after two corrected seconds to confirm that the phase restarts.

// File: rtl/rtcTickPkg.sv
package rtcTickPkg;
  // strobes sent from control to datapath each cycle
  typedef struct packed {
    logic load;   // take a new calibration word, restart the second
    logic wrap;   // end of second reached
  } tickStrobes_t;
endpackage

// File: rtl/rtcTickDatapath.sv
module rtcTickDatapath
  import rtcTickPkg::*;
#(
  parameter int TICK_W = 16,
  parameter int FRAC_W = 4,
  parameter int BUS_W = 32,
  parameter int CAL_W = TICK_W + FRAC_W + 1,
  parameter logic [CAL_W-1:0] CAL_RESET = 21'h198233
) (
  input  logic               clk,
  input  logic               rstN,
  input  tickStrobes_t       strobes,
  input  logic [BUS_W-1:0]   calData,
  output logic [CAL_W-1:0]   calQ,
  output logic [TICK_W:0]    tickQ,
  output logic [FRAC_W-1:0]  phaseQ,
  output logic               secPulse
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      calQ     <= CAL_RESET;
      tickQ    <= '0;
      phaseQ   <= '0;
      secPulse <= 1'b0;
    end else if (strobes.load) begin
      calQ     <= calData[CAL_W-1:0];
      tickQ    <= '0;
      phaseQ   <= '0;
      secPulse <= 1'b0;
    end else if (strobes.wrap) begin
      tickQ    <= '0;
      phaseQ   <= phaseQ + 1'b1;
      secPulse <= 1'b1;
    end else begin
      tickQ    <= tickQ + 1'b1;
      secPulse <= 1'b0;
    end
  end
endmodule

// File: rtl/rtcTickCtrl.sv
module rtcTickCtrl
  import rtcTickPkg::*;
#(
  parameter int TICK_W = 16,
  parameter int FRAC_W = 4,
  parameter int CAL_W = TICK_W + FRAC_W + 1
) (
  input  logic               calWr,
  input  logic [CAL_W-1:0]   calQ,
  input  logic [TICK_W:0]    tickQ,
  input  logic [FRAC_W-1:0]  phaseQ,
  output tickStrobes_t       strobes
);
  localparam int FRAC_LSB = TICK_W;
  localparam int EN_BIT   = CAL_W - 1;

  logic [TICK_W-1:0] intCount;
  logic [FRAC_W-1:0] fracVal;
  logic              fracOn;
  logic              stretch;
  logic [TICK_W:0]   limit;

  always_comb begin
    intCount = calQ[TICK_W-1:0];
    fracVal  = calQ[FRAC_LSB +: FRAC_W];
    fracOn   = calQ[EN_BIT];
    // one extra cycle in seconds whose phase lies below the fraction
    stretch  = fracOn && (phaseQ < fracVal);
    limit    = {1'b0, intCount} + {{TICK_W{1'b0}}, stretch};
    strobes.load = calWr;
    strobes.wrap = !calWr && (tickQ == limit);
  end
endmodule

// File: rtl/rtcSecTick.sv
module rtcSecTick
  import rtcTickPkg::*;
#(
  parameter int TICK_W = 16,
  parameter int FRAC_W = 4,
  parameter int BUS_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              calWr,
  input  logic [BUS_W-1:0]  calData,
  output logic              secPulse,
  output logic [TICK_W-1:0] tickCount
);
  localparam int CAL_W = TICK_W + FRAC_W + 1;
  localparam logic [CAL_W-1:0] CAL_RESET = CAL_W'(21'h198233);

  tickStrobes_t       strobes;
  logic [CAL_W-1:0]   calQ;
  logic [TICK_W:0]    tickQ;
  logic [FRAC_W-1:0]  phaseQ;

  rtcTickCtrl #(.TICK_W(TICK_W), .FRAC_W(FRAC_W), .CAL_W(CAL_W)) ctrl (
    .calWr(calWr), .calQ(calQ), .tickQ(tickQ), .phaseQ(phaseQ), .strobes(strobes)
  );

  rtcTickDatapath #(.TICK_W(TICK_W), .FRAC_W(FRAC_W), .BUS_W(BUS_W),
                    .CAL_W(CAL_W), .CAL_RESET(CAL_RESET)) dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .calData(calData),
    .calQ(calQ), .tickQ(tickQ), .phaseQ(phaseQ), .secPulse(secPulse)
  );

  assign tickCount = tickQ[TICK_W-1:0];
endmodule

// File: rtl/rtcSecTickChecker.sv
module rtcSecTickChecker #(
  parameter int TICK_W = 16,
  parameter int FRAC_W = 4,
  parameter int BUS_W = 32,
  parameter int CAL_W = TICK_W + FRAC_W + 1
) (
  input logic              clk,
  input logic              rstN,
  input logic              calWr,
  input logic [BUS_W-1:0]  calData,
  input logic              secPulse,
  input logic [TICK_W-1:0] tickCount,
  input logic [CAL_W-1:0]  calQ,
  input logic [FRAC_W-1:0] phaseQ
);
  a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    (secPulse && !calWr && (calQ[TICK_W-1:0] != '0)) |=> !secPulse);

  a_r4_phase_step: assert property (@(posedge clk) disable iff (!rstN)
    !calWr |=> (!secPulse || phaseQ == FRAC_W'($past(phaseQ) + 1'b1)));

  a_r6_write_restart: assert property (@(posedge clk) disable iff (!rstN)
    calWr |=> (tickCount == '0 && !secPulse));

  a_r7_phase_clear: assert property (@(posedge clk) disable iff (!rstN)
    calWr |=> phaseQ == '0);

  a_r8_upper_ignored: assert property (@(posedge clk) disable iff (!rstN)
    calWr |=> calQ == $past(calData[CAL_W-1:0]));

  a_r9_tick_ramp: assert property (@(posedge clk) disable iff (!rstN)
    !calWr |=> (secPulse || tickCount == TICK_W'($past(tickCount) + 1'b1)));

  a_r9_zero_at_pulse: assert property (@(posedge clk) disable iff (!rstN)
    secPulse |-> tickCount == '0);
endmodule

bind rtcSecTick rtcSecTickChecker #(.TICK_W(TICK_W), .FRAC_W(FRAC_W), .BUS_W(BUS_W)) chk (
  .clk(clk), .rstN(rstN), .calWr(calWr), .calData(calData), .secPulse(secPulse),
  .tickCount(tickCount), .calQ(calQ), .phaseQ(phaseQ)
);

// File: tb/rtcSecTick_test.sv
module rtcSecTick_test;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 7;
  // calibration word, first second length, sixteen-second total, requirement
  localparam logic [31:0] VEC_WORD [NV] = '{32'h00000003, 32'h00020003, 32'h00120003,
                                            32'h001F0007, 32'h00100005, 32'hFFE00004,
                                            32'h00110001};
  localparam int VEC_FIRST [NV] = '{4, 4, 5, 9, 6, 5, 3};
  localparam int VEC_SUM   [NV] = '{64, 64, 66, 143, 96, 80, 33};
  // R2, R5, R4, R4, R4, R8, R4
  localparam int VEC_REQ   [NV] = '{2, 5, 4, 4, 4, 8, 4};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic calWr = 1'b0;
  logic [31:0] calData = '0;
  logic secPulse;
  logic [15:0] tickCount;
  int total = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtcSecTick uut (.clk(clk), .rstN(rstN), .calWr(calWr), .calData(calData),
                  .secPulse(secPulse), .tickCount(tickCount));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic writeCal(input logic [31:0] w);
    @(negedge clk);
    calWr = 1'b1;
    calData = w;
    @(posedge clk);
    #1;
    calWr = 1'b0;
    calData = '0;
  endtask

  task automatic waitPulse(output int n);
    n = 0;
    do begin
      @(posedge clk);
      #1;
      n++;
    end while (!secPulse && n < 100000);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    int n;
    int sum;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check(tickCount == 0, "R1 tick at reset", tickCount, 0);
    check(secPulse == 0, "R1 pulse at reset", secPulse, 0);
    @(negedge clk);
    rstN = 1'b1;
    waitPulse(n);
    check(n == 33333, "R1 default second", n, 33333);

    // vector table: R2 R4 R5 R8
    for (int v = 0; v < NV; v++) begin
      writeCal(VEC_WORD[v]);
      waitPulse(n);
      check(n == VEC_FIRST[v], $sformatf("R%0d first second vec %0d", VEC_REQ[v], v),
            n, VEC_FIRST[v]);
      sum = n;
      for (int s = 1; s < 16; s++) begin
        waitPulse(n);
        sum += n;
      end
      check(sum == VEC_SUM[v], $sformatf("R%0d sixteen seconds vec %0d", VEC_REQ[v], v),
            sum, VEC_SUM[v]);
      @(posedge clk);
      #1;
      check(secPulse == 0, "R3 pulse width", secPulse, 0);
    end

    // R9 tick ramp
    writeCal(32'h00000009);
    check(tickCount == 0, "R9 tick after write", tickCount, 0);
    for (int k = 1; k <= 9; k++) begin
      @(posedge clk);
      #1;
      if (tickCount != k[15:0] || secPulse)
        check(1'b0, "R9 ramp", tickCount, k);
    end
    total++;
    @(posedge clk);
    #1;
    check(secPulse == 1 && tickCount == 0, "R9 pulse with zero tick", tickCount, 0);

    // R6 mid-second rewrite
    repeat (4) @(posedge clk);
    writeCal(32'h00000009);
    check(tickCount == 0 && secPulse == 0, "R6 tick cleared", tickCount, 0);
    waitPulse(n);
    check(n == 10, "R6 full second after write", n, 10);

    // R7 phase reset by rewrite after two corrected seconds
    writeCal(32'h00120003);
    waitPulse(n);
    waitPulse(n);
    writeCal(32'h00120003);
    waitPulse(n);
    check(n == 5, "R7 first second after rewrite", n, 5);
    waitPulse(n);
    check(n == 5, "R7 second second", n, 5);
    waitPulse(n);
    check(n == 4, "R7 third second", n, 4);

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule